// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block keeps the 32 most recently used page translations close to the address path, so that a translated address comes back without any memory access. A 32-bit linear address is split into a 20-bit page tag (bits 31:12) and a 12-bit offset (bits 11:0). The tag is compared with every stored entry at once. On a hit the block returns the physical address, which is the stored 20-bit frame followed by the unchanged offset, together with four stored attribute bits. On a miss it raises a miss flag so that an external table walker can fetch the translation and write it back through the fill channel.

Lookup is purely combinational. The fill channel is a valid/ready stream. `fill_ready` drops only in a cycle where `flush` is high. A fill beat is taken on a rising edge where both `fill_valid` and `fill_ready` are high. The sender must hold the beat until it is taken. A flush invalidates entries on the next edge. When the global-page enable is high, entries marked global survive the flush.

Top module: `xlat_buf`

## Requirements
- R1: After reset every entry is invalid, the replacement pointer is 0, and every lookup misses.
- R2: When `lk_valid` is high and the tag of `lk_vaddr` (bits 31:12) matches a valid entry, `lk_hit` is high in the same cycle and `lk_paddr` is that entry's frame in bits 31:12 with `lk_vaddr[11:0]` in bits 11:0.
- R3: On a hit, `lk_attr` returns the four attribute bits stored with the entry, ordered {read/write, user/supervisor, dirty, global} from bit 3 down to bit 0.
- R4: When `lk_valid` is high and no valid entry matches, `lk_miss` is high and `lk_hit` is low. When `lk_valid` is low, both are low.
- R5: `fill_ready` equals the inverse of `flush`. An accepted fill can be looked up from the cycle after its clock edge, and not in the cycle before.
- R6: A fill with a new tag goes to the lowest-numbered invalid entry if one exists.
- R7: When no entry is invalid, a fill with a new tag replaces the entry chosen by a round-robin pointer. The pointer then advances by one, modulo 32. It moves on no other event.
- R8: A fill whose tag matches a valid entry overwrites that entry in place, so no tag is ever held twice.
- R9: A flush with `glob_en` low invalidates every entry, global ones included.
- R10: A flush with `glob_en` high invalidates every entry except those whose global attribute bit is set.
- R11: A fill presented in the same cycle as a flush is not accepted and changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Linear address to translate |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_miss | output | 1 | Lookup found no valid entry |
| lk_paddr | output | 32 | Translated physical address |
| lk_attr | output | 4 | {rw, us, dirty, global} of the matched entry |
| fill_valid | input | 1 | Fill beat offered |
| fill_ready | output | 1 | Fill beat can be taken this cycle |
| fill_tag | input | 20 | Page tag to install |
| fill_frame | input | 20 | Physical frame to install |
| fill_attr | input | 4 | {rw, us, dirty, global} to install |
| flush | input | 1 | Invalidate entries on the next edge |
| glob_en | input | 1 | Keep global entries on a flush |

## Verification
The hardest state to reach from the ports is a full buffer, where the round-robin pointer picks the victim, combined with holes that a global-preserving flush punches at scattered positions. That combination decides whether a fill goes to the lowest hole, to a duplicate, or to the pointer. A directed sequence fills all 32 entries with every fourth one global, forces two pointer evictions with an in-place overwrite between them, and then flushes. The random phase draws tags from a pool only a little larger than the buffer and mixes in occasional flushes with a random `glob_en`. This keeps the buffer cycling between full and partly empty while a bench model follows the expected contents.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  // attribute bits kept beside every translation, MSB first
  typedef struct packed {
    logic rw;
    logic us;
    logic dirty;
    logic glob;
  } xlat_attr_t;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int N     = 32,
  parameter int TAG_W = 20
) (
  input  logic [N-1:0]            vld,
  input  logic [N-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]        key,
  output logic [N-1:0]            hit
);
  // one comparator per entry, all in parallel
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = vld[g] && (tags[g] == key);
  end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     vld,
  input  logic [N-1:0]     dup,
  input  logic             take,
  output logic [IDX_W-1:0] vic_idx,
  output logic             by_ptr
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] dup_idx;
  logic [IDX_W-1:0] hole_idx;

  always_comb begin
    dup_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (dup[i]) dup_idx = dup_idx | IDX_W'(i);
    end
  end

  // lowest-numbered invalid entry
  always_comb begin
    hole_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld[i]) hole_idx = IDX_W'(i);
    end
  end

  always_comb begin
    by_ptr = 1'b0;
    if (|dup)          vic_idx = dup_idx;
    else if (!(&vld))  vic_idx = hole_idx;
    else begin
      vic_idx = ptr_q;
      by_ptr  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else if (take && by_ptr)
      ptr_q <= (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
  end

  p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && by_ptr && ptr_q != IDX_W'(N - 1)) |=> (ptr_q == $past(ptr_q) + 1'b1));
  p_ptr_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && by_ptr && ptr_q == IDX_W'(N - 1)) |=> (ptr_q == '0));
  p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && by_ptr) |=> $stable(ptr_q));
  p_ptr_only_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (by_ptr |-> (&vld) && !(|dup)));
endmodule

// File: rtl/xlat_buf.sv
module xlat_buf
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int ATTR_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lk_valid,
  input  logic [VA_W-1:0]     lk_vaddr,
  output logic                lk_hit,
  output logic                lk_miss,
  output logic [PA_W-1:0]     lk_paddr,
  output logic [ATTR_W-1:0]   lk_attr,
  input  logic                fill_valid,
  output logic                fill_ready,
  input  logic [VA_W-OFF_W-1:0] fill_tag,
  input  logic [PA_W-OFF_W-1:0] fill_frame,
  input  logic [ATTR_W-1:0]   fill_attr,
  input  logic                flush,
  input  logic                glob_en
);
  localparam int TAG_W = VA_W - OFF_W;
  localparam int FRM_W = PA_W - OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]            vld_q;
  logic [ENTRIES-1:0][TAG_W-1:0] tag_q;
  logic [ENTRIES-1:0][FRM_W-1:0] frm_q;
  xlat_attr_t [ENTRIES-1:0]      attr_q;
  logic [ENTRIES-1:0]            glob_vec;

  logic [ENTRIES-1:0] lk_vec, fl_vec;
  logic [IDX_W-1:0]   lk_idx, vic_idx;
  logic               by_ptr, fill_go;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_glob
    assign glob_vec[g] = attr_q[g].glob;
  end

  xlat_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_lk_match (
    .vld(vld_q), .tags(tag_q), .key(lk_vaddr[VA_W-1:OFF_W]), .hit(lk_vec));

  xlat_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_fill_match (
    .vld(vld_q), .tags(tag_q), .key(fill_tag), .hit(fl_vec));

  assign fill_ready = !flush;
  assign fill_go    = fill_valid && fill_ready;

  xlat_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .vld(vld_q), .dup(fl_vec), .take(fill_go),
    .vic_idx(vic_idx), .by_ptr(by_ptr));

  // encode the (at most one-hot) lookup match
  always_comb begin
    lk_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_vec[i]) lk_idx = lk_idx | IDX_W'(i);
    end
  end

  assign lk_hit   = lk_valid && (|lk_vec);
  assign lk_miss  = lk_valid && !(|lk_vec);
  assign lk_paddr = {frm_q[lk_idx], lk_vaddr[OFF_W-1:0]};
  assign lk_attr  = lk_hit ? attr_q[lk_idx] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else if (flush) vld_q <= glob_en ? (vld_q & glob_vec) : '0;
    else if (fill_go) vld_q[vic_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_go) begin
      tag_q[vic_idx]  <= fill_tag;
      frm_q[vic_idx]  <= fill_frame;
      attr_q[vic_idx] <= fill_attr;
    end
  end

  p_hit_miss_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss));
  p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));
  p_single_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_vec) && $onehot0(fl_vec));
  p_flush_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !glob_en) |=> (vld_q == '0));
  p_flush_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && glob_en) |=> ((vld_q & ~glob_vec) == '0));
  p_flush_no_grow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ($countones(vld_q) <= $countones($past(vld_q))));
  p_fill_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go |=> (|vld_q));
endmodule

// File: tb/tb_xlat_buf.sv
`timescale 1ns/1ps
module tb_xlat_buf;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid;
  logic [31:0] lk_vaddr;
  logic        lk_hit, lk_miss;
  logic [31:0] lk_paddr;
  logic [3:0]  lk_attr;
  logic        fill_valid, fill_ready;
  logic [19:0] fill_tag, fill_frame;
  logic [3:0]  fill_attr;
  logic        flush, glob_en;

  int total = 0;
  int bad   = 0;

  bit          m_v   [32];
  logic [19:0] m_tag [32];
  logic [19:0] m_frm [32];
  logic [3:0]  m_attr[32];
  int          m_ptr;

  always #2.5 clk = ~clk;

  xlat_buf dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr), .lk_attr(lk_attr),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_tag(fill_tag),
    .fill_frame(fill_frame), .fill_attr(fill_attr), .flush(flush), .glob_en(glob_en));

  function automatic int m_find(input logic [19:0] t);
    for (int i = 0; i < 32; i++) if (m_v[i] && m_tag[i] == t) return i;
    return -1;
  endfunction

  function automatic logic [31:0] exp_pa(input int idx, input logic [31:0] va);
    return {m_frm[idx], va[11:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one cycle: drive after the falling edge, check the comb outputs, then
  // advance the model to the state the next rising edge produces
  task automatic cyc(input bit lv, input logic [31:0] va, input bit fv,
                     input logic [19:0] ft, input logic [19:0] ff,
                     input logic [3:0] fa, input bit fl, input bit g,
                     input string req);
    int idx;
    @(negedge clk);
    lk_valid = lv; lk_vaddr = va; fill_valid = fv; fill_tag = ft;
    fill_frame = ff; fill_attr = fa; flush = fl; glob_en = g;
    #1;
    idx = m_find(va[31:12]);
    chk(lk_hit == (lv && idx >= 0), req, "hit", 64'(lk_hit), 64'(lv && idx >= 0));
    chk(lk_miss == (lv && idx < 0), {req, "/R4"}, "miss", 64'(lk_miss), 64'(lv && idx < 0));
    if (lv && idx >= 0) begin
      chk(lk_paddr == exp_pa(idx, va), {req, "/R2"}, "paddr", 64'(lk_paddr), 64'(exp_pa(idx, va)));
      chk(lk_attr == m_attr[idx], {req, "/R3"}, "attr", 64'(lk_attr), 64'(m_attr[idx]));
    end
    chk(fill_ready == !fl, "R5", "fill_ready", 64'(fill_ready), 64'(!fl));
    if (fl) begin
      for (int i = 0; i < 32; i++) if (!(g && m_attr[i][0])) m_v[i] = 1'b0;
    end else if (fv) begin
      idx = m_find(ft);
      if (idx < 0) for (int i = 31; i >= 0; i--) if (!m_v[i]) idx = i;
      if (idx < 0) begin
        idx = m_ptr;
        m_ptr = (m_ptr + 1) % 32;
      end
      m_v[idx] = 1'b1; m_tag[idx] = ft; m_frm[idx] = ff; m_attr[idx] = fa;
    end
  endtask

  task automatic look(input logic [19:0] t, input bit exp, input string req);
    cyc(1'b1, {t, 12'h5a5}, 1'b0, '0, '0, '0, 1'b0, 1'b0, req);
    chk(lk_hit == exp, req, "directed hit", 64'(lk_hit), 64'(exp));
  endtask

  task automatic fill(input logic [19:0] t, input logic [19:0] f, input logic [3:0] a);
    cyc(1'b0, '0, 1'b1, t, f, a, 1'b0, 1'b0, "R5");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) begin
      m_v[i] = 1'b0; m_tag[i] = '0; m_frm[i] = '0; m_attr[i] = '0;
    end
    m_ptr = 0;
    rst_n = 1'b0; lk_valid = 0; lk_vaddr = '0; fill_valid = 0; fill_tag = '0;
    fill_frame = '0; fill_attr = '0; flush = 0; glob_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: empty after reset
    look(20'h00000, 1'b0, "R1");
    look(20'hA0003, 1'b0, "R1");

    // R6: fill every entry, every fourth one global
    for (int i = 0; i < 32; i++)
      fill(20'hA0000 + 20'(i), 20'h30000 + 20'(i), (i % 4 == 0) ? 4'b1001 : 4'b0110);
    look(20'hA0000, 1'b1, "R6");
    look(20'hA001F, 1'b1, "R6");
    // R7: full buffer, pointer 0 evicts the first tag
    fill(20'hA0020, 20'h3ABCD, 4'b1101);
    look(20'hA0000, 1'b0, "R7");
    look(20'hA0020, 1'b1, "R7");
    // R8: overwrite in place, pointer stays at 1
    fill(20'hA0005, 20'h3FFFF, 4'b1010);
    look(20'hA0005, 1'b1, "R8");
    chk(lk_paddr == 32'h3FFFF5A5, "R8", "new frame", 64'(lk_paddr), 64'h3FFFF5A5);
    fill(20'hA0021, 20'h31111, 4'b0000);
    look(20'hA0001, 1'b0, "R7");
    look(20'hA0002, 1'b1, "R8");
    // R10: global-preserving flush
    cyc(1'b0, '0, 1'b0, '0, '0, '0, 1'b1, 1'b1, "R10");
    look(20'hA0004, 1'b1, "R10");
    look(20'hA0020, 1'b1, "R10");
    look(20'hA0002, 1'b0, "R10");
    // R6: refill goes to the lowest hole
    fill(20'hA0040, 20'h32222, 4'b0100);
    look(20'hA0040, 1'b1, "R6");
    // R11: fill during flush is dropped
    cyc(1'b0, '0, 1'b1, 20'hA0041, 20'h33333, 4'b0001, 1'b1, 1'b1, "R11");
    look(20'hA0041, 1'b0, "R11");
    // R9: plain flush clears global entries too
    cyc(1'b0, '0, 1'b0, '0, '0, '0, 1'b1, 1'b0, "R9");
    look(20'hA0004, 1'b0, "R9");
    look(20'hA0020, 1'b0, "R9");
    // R4: no request, no flags
    cyc(1'b0, 32'hA0004000, 1'b0, '0, '0, '0, 1'b0, 1'b0, "R4");

    // random mix against the model
    for (int n = 0; n < 4000; n++) begin
      logic [19:0] lt, ft;
      bit lv, fv, fl;
      lt = ($urandom_range(0, 15) == 0) ? 20'($urandom) : 20'h40000 + 20'($urandom_range(0, 47));
      ft = 20'h40000 + 20'($urandom_range(0, 47));
      lv = $urandom_range(0, 9) < 8;
      fv = $urandom_range(0, 1);
      fl = $urandom_range(0, 39) == 0;
      cyc(lv, {lt, 12'($urandom)}, fv, ft, 20'($urandom), 4'($urandom), fl,
          1'($urandom), "R2");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule